// File: doc/BRIEF.md
# Two-Phase Bus Write Strobe Generator

This block sits between a processor bus clocked by two quarter-shifted phases (E and Q) and an asynchronous register-file peripheral that stores data on the rising edge of an active-low write pulse. It runs from a fast system clock and brings E and Q into that clock domain through synchronizer chains. When E rises while Q is high and the bus carries a selected write, the block starts one write cycle. It asserts the peripheral select and latches the register index. It waits out a setup interval, drives the write pulse for a fixed width, and keeps select and index steady for a hold interval. It then waits for E to fall before it can start another cycle.

Every timing limit is a nanosecond parameter. The block turns each limit into clock counts by rounding up and adding one cycle of margin. The bus rate parameter (0 for 1 MHz, 1 for 1.5 MHz, 2 for 2 MHz) sets the E-high window and the minimum Q-to-E lead (200, 130 or 80 ns). From these the block computes a static configuration-error flag. The flag is set when synchronizer latency, setup, pulse and hold cannot fit in half a bus period, or when the address lead cannot cover the select setup.

All pins are plain levels. There is no data stream and no back-pressure, because the processor bus cannot be stalled. Any write that cannot be placed shows only through the configuration-error flag.

Top module: `bus_wstrobe_gen`

## Requirements
- R1: While reset is asserted, and after it until a write is started, per_cs_n and per_wr_n are both high.
- R2: A write cycle starts in the third clock after the first clock edge that samples bus_e high following a low sample. This requires bus_q to have been high two samples earlier, bus_rw low and bus_cs high at the starting edge. per_cs_n goes low at that edge.
- R3: per_wr_n falls exactly SETUP cycles after per_cs_n falls. SETUP is the larger of ceil(data setup / clock period) and ceil(select setup / clock period), plus one. per_wr_n is never low while per_cs_n is high.
- R4: per_wr_n stays low for exactly ceil(pulse / clock period) + 1 cycles.
- R5: per_cs_n stays low for exactly ceil(hold / clock period) + 1 cycles after per_wr_n rises.
- R6: A bus cycle whose bus_rw is high, or whose bus_cs is low, at the starting edge produces no select and no strobe. This holds even if the bus turns into a write later while E is high.
- R7: At most one strobe is issued per E-high phase. After a cycle ends, the block starts another only after the synchronized E has been seen low.
- R8: per_rs takes bus_rs at the starting edge and does not change while per_cs_n is low.
- R9: cfg_err is 1 exactly when (3 + SETUP + PULSE + HOLD) x clock period exceeds half the bus period (500, 333 or 250 ns), or when the Q-to-E lead plus (3 + SETUP) cycles is shorter than the select setup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_e | input | 1 | Bus E phase (asynchronous) |
| bus_q | input | 1 | Bus Q phase (asynchronous) |
| bus_rw | input | 1 | Bus read/write, low for write |
| bus_cs | input | 1 | Decoded chip select, active high |
| bus_rs | input | RS_W | Register index from the bus address |
| per_cs_n | output | 1 | Peripheral select, active low |
| per_rs | output | RS_W | Register index held for the peripheral |
| per_wr_n | output | 1 | Peripheral write strobe, active low |
| cfg_err | output | 1 | Parameters cannot fit the E-high window |

## Verification
A wrong count in the setup, pulse or hold counter shows on the next write cycle. per_wr_n falls, or per_cs_n rises, one or more clocks away from the predicted edge, and the every-clock comparison reports it at once. A sequencer that leaves its waiting state too early shows as a second select within the same E-high phase. One that starts on a read or on a late-turning write shows as a select where the model expects none. Both appear within a few clocks of the bus edge. A register index captured at the wrong edge shows as a per_rs mismatch while select is low.

// File: rtl/bws_pkg.sv
package bws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } wstate_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  // half of the bus period in ns, i.e. the E-high window
  function automatic int unsigned half_period_ns(input int unsigned rate);
    case (rate)
      0:       return 500;
      1:       return 333;
      default: return 250;
    endcase
  endfunction

  // minimum lead of Q rise over E rise in ns
  function automatic int unsigned qe_lead_min_ns(input int unsigned rate);
    case (rate)
      0:       return 200;
      1:       return 130;
      default: return 80;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bws_sync.sv
module bws_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/bws_edge.sv
module bws_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);

  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;

endmodule

// File: rtl/bws_seq.sv
module bws_seq
  import bws_pkg::*;
#(
  parameter int unsigned RS_W      = 3,
  parameter int unsigned SETUP_CYC = 20,
  parameter int unsigned PULSE_CYC = 20,
  parameter int unsigned HOLD_CYC  = 6,
  parameter int unsigned CNT_W     = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            e_rise,
  input  logic            e_lvl,
  input  logic            q_lvl,
  input  logic            rw,
  input  logic            cs,
  input  logic [RS_W-1:0] rs,
  output logic            sel_n,
  output logic            wr_n,
  output logic [RS_W-1:0] rs_q
);

  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);

  wstate_e          state;
  logic [CNT_W-1:0] cnt;
  logic             go;

  assign go = e_rise & q_lvl & ~rw & cs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      sel_n <= 1'b1;
      wr_n  <= 1'b1;
      rs_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (go) begin
            state <= ST_SETUP;
            cnt   <= LD_SETUP;
            sel_n <= 1'b0;
            rs_q  <= rs;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_STROBE;
            cnt   <= LD_PULSE;
            wr_n  <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (cnt == '0) begin
            state <= ST_HOLD;
            cnt   <= LD_HOLD;
            wr_n  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            state <= ST_DONE;
            sel_n <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_DONE: begin
          if (!e_lvl) state <= ST_IDLE;
        end
        default: begin
          state <= ST_IDLE;
          sel_n <= 1'b1;
          wr_n  <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/bus_wstrobe_gen.sv
module bus_wstrobe_gen
  import bws_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned BUS_RATE      = 0,
  parameter int unsigned SEL_SETUP_NS  = 20,
  parameter int unsigned DATA_SETUP_NS = 75,
  parameter int unsigned PULSE_NS      = 75,
  parameter int unsigned HOLD_NS       = 20,
  parameter int unsigned MARGIN_CYC    = 1,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned RS_W          = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_e,
  input  logic            bus_q,
  input  logic            bus_rw,
  input  logic            bus_cs,
  input  logic [RS_W-1:0] bus_rs,
  output logic            per_cs_n,
  output logic [RS_W-1:0] per_rs,
  output logic            per_wr_n,
  output logic            cfg_err
);

  localparam int unsigned LAT_CYC   = SYNC_STAGES + 1;
  localparam int unsigned DSET_CYC  = ceil_div(DATA_SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned SSET_CYC  = ceil_div(SEL_SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned SETUP_CYC = ((DSET_CYC > SSET_CYC) ? DSET_CYC : SSET_CYC) + MARGIN_CYC;
  localparam int unsigned PULSE_CYC = ceil_div(PULSE_NS, CLK_PERIOD_NS) + MARGIN_CYC;
  localparam int unsigned HOLD_CYC  = ceil_div(HOLD_NS, CLK_PERIOD_NS) + MARGIN_CYC;
  localparam int unsigned CNT_W     = $clog2(max3(SETUP_CYC, PULSE_CYC, HOLD_CYC) + 1);
  localparam int unsigned BUSY_NS   = (LAT_CYC + SETUP_CYC + PULSE_CYC + HOLD_CYC) * CLK_PERIOD_NS;
  localparam int unsigned LEAD_NS   = qe_lead_min_ns(BUS_RATE) + (LAT_CYC + SETUP_CYC) * CLK_PERIOD_NS;
  localparam bit          CFG_BAD   = (BUSY_NS > half_period_ns(BUS_RATE)) || (LEAD_NS < SEL_SETUP_NS);

  logic [1:0] ph_sync;
  logic       e_rise;

  bws_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({bus_q, bus_e}),
    .dout (ph_sync)
  );

  bws_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (ph_sync[0]),
    .rise (e_rise)
  );

  bws_seq #(
    .RS_W     (RS_W),
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .e_rise(e_rise),
    .e_lvl (ph_sync[0]),
    .q_lvl (ph_sync[1]),
    .rw    (bus_rw),
    .cs    (bus_cs),
    .rs    (bus_rs),
    .sel_n (per_cs_n),
    .wr_n  (per_wr_n),
    .rs_q  (per_rs)
  );

  assign cfg_err = CFG_BAD;

endmodule

// File: rtl/bus_wstrobe_gen_chk.sv
module bus_wstrobe_gen_chk #(
  parameter int unsigned RS_W      = 3,
  parameter int unsigned SETUP_CYC = 20,
  parameter int unsigned PULSE_CYC = 20,
  parameter int unsigned HOLD_CYC  = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_rw,
  input logic            bus_cs,
  input logic            per_cs_n,
  input logic            per_wr_n,
  input logic [RS_W-1:0] per_rs
);

  logic [15:0] sel_run;
  logic [15:0] wr_run;
  logic [15:0] hold_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_run  <= '0;
      wr_run   <= '0;
      hold_run <= '0;
    end else begin
      sel_run  <= per_cs_n ? 16'd0 : ((sel_run == 16'hFFFF) ? sel_run : sel_run + 16'd1);
      wr_run   <= per_wr_n ? 16'd0 : ((wr_run == 16'hFFFF) ? wr_run : wr_run + 16'd1);
      hold_run <= (per_cs_n || !per_wr_n) ? 16'd0 :
                  ((hold_run == 16'hFFFF) ? hold_run : hold_run + 16'd1);
    end
  end

  AST_STROBE_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !per_wr_n |-> !per_cs_n); // R3

  AST_SETUP_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_wr_n) |-> (sel_run == 16'(SETUP_CYC))); // R3

  AST_PULSE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_wr_n) |-> (wr_run == 16'(PULSE_CYC))); // R4

  AST_HOLD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_cs_n) |-> (hold_run == 16'(HOLD_CYC))); // R5

  AST_WRITE_ONLY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_cs_n) |-> (!$past(bus_rw) && $past(bus_cs))); // R6

  AST_INDEX_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_cs_n && !$past(per_cs_n)) |-> $stable(per_rs)); // R8

endmodule

bind bus_wstrobe_gen bus_wstrobe_gen_chk #(
  .RS_W     (RS_W),
  .SETUP_CYC(SETUP_CYC),
  .PULSE_CYC(PULSE_CYC),
  .HOLD_CYC (HOLD_CYC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_rw  (bus_rw),
  .bus_cs  (bus_cs),
  .per_cs_n(per_cs_n),
  .per_wr_n(per_wr_n),
  .per_rs  (per_rs)
);

// File: tb/bus_wstrobe_gen_bench.sv
`timescale 1ns/1ps
module bus_wstrobe_gen_bench;

  localparam int CLK_NS = 4;
  localparam int WD_CYC = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   checks = 0;
  int   failures = 0;
  int   done_cnt = 0;

  always #(CLK_NS/2) clk = ~clk;

  for (genvar g = 0; g < 4; g++) begin : g_blk
    localparam int RATE  = (g == 3) ? 2 : g;
    localparam int PNS   = (g == 3) ? 200 : 75;
    localparam int QC    = (RATE == 0) ? 62 : ((RATE == 1) ? 41 : 31);
    localparam int S_E   = (((75 + CLK_NS - 1) / CLK_NS) > ((20 + CLK_NS - 1) / CLK_NS) ?
                            ((75 + CLK_NS - 1) / CLK_NS) : ((20 + CLK_NS - 1) / CLK_NS)) + 1;
    localparam int P_E   = (PNS + CLK_NS - 1) / CLK_NS + 1;
    localparam int H_E   = (20 + CLK_NS - 1) / CLK_NS + 1;
    localparam int HALF  = (RATE == 0) ? 500 : ((RATE == 1) ? 333 : 250);
    localparam int QMIN  = (RATE == 0) ? 200 : ((RATE == 1) ? 130 : 80);
    localparam bit ERR_E = ((3 + S_E + P_E + H_E) * CLK_NS > HALF) ||
                           (QMIN + (3 + S_E) * CLK_NS < 20);

    logic       bus_e = 1'b0, bus_q = 1'b0, bus_rw = 1'b1, bus_cs = 1'b0;
    logic [2:0] bus_rs = '0;
    logic       per_cs_n, per_wr_n, cfg_err;
    logic [2:0] per_rs;

    bus_wstrobe_gen #(.BUS_RATE(RATE), .PULSE_NS(PNS)) u_bus_wstrobe_gen (
      .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_q(bus_q), .bus_rw(bus_rw),
      .bus_cs(bus_cs), .bus_rs(bus_rs), .per_cs_n(per_cs_n), .per_rs(per_rs),
      .per_wr_n(per_wr_n), .cfg_err(cfg_err)
    );

    // reference model: t = 0 idle, 1.. cycle position, -1 waiting for E low
    bit         eq[$] = '{0, 0, 0, 0};
    bit         qq[$] = '{0, 0, 0, 0};
    int         t = 0;
    logic [2:0] rs_exp = '0;
    int         strobes = 0;
    int         want_strobes = 0;
    logic       wr_prev = 1'b1;

    always @(posedge clk) begin
      if (!rst_n) begin
        eq = '{0, 0, 0, 0};
        qq = '{0, 0, 0, 0};
        t  = 0;
      end else begin
        eq.push_front(bus_e); void'(eq.pop_back());
        qq.push_front(bus_q); void'(qq.pop_back());
        if (t == 0) begin
          if (eq[2] && !eq[3] && qq[2] && !bus_rw && bus_cs) begin
            t = 1;
            rs_exp = bus_rs;
          end
        end else if (t > 0) begin
          t++;
          if (t > S_E + P_E + H_E) t = -1;
        end else if (!eq[2]) begin
          t = 0;
        end
      end
    end

    function automatic string phase_req(input int tt);
      if (tt == 0)               return "R6";
      if (tt < 0)                return "R7";
      if (tt == 1)               return "R2";
      if (tt <= S_E)             return "R3";
      if (tt <= S_E + P_E)       return "R4";
      return "R5";
    endfunction

    always @(negedge clk) begin
      if (rst_n) begin
        logic ecs, ewr;
        ecs = !(t >= 1 && t <= S_E + P_E + H_E);
        ewr = !(t >= S_E + 1 && t <= S_E + P_E);
        checks++;
        if (per_cs_n !== ecs) begin
          failures++;
          $display("FAIL %s blk%0d per_cs_n actual=%b expected=%b", phase_req(t), g, per_cs_n, ecs);
        end
        checks++;
        if (per_wr_n !== ewr) begin
          failures++;
          $display("FAIL %s blk%0d per_wr_n actual=%b expected=%b", phase_req(t), g, per_wr_n, ewr);
        end
        if (!ecs) begin
          checks++;
          if (per_rs !== rs_exp) begin
            failures++;
            $display("FAIL R8 blk%0d per_rs actual=%0d expected=%0d", g, per_rs, rs_exp);
          end
        end
        if (wr_prev && !per_wr_n) strobes++;
        wr_prev = per_wr_n;
      end
    end

    task automatic bus_cycle(input logic rw_i, input logic cs_i, input logic [2:0] rs_i,
                             input bit late);
      @(negedge clk);
      bus_q  = 1'b1;
      bus_rw = late ? 1'b1 : rw_i;
      bus_cs = cs_i;
      bus_rs = rs_i;
      repeat (QC) @(negedge clk);
      bus_e = 1'b1;
      if (late) begin
        repeat (5) @(negedge clk);
        bus_rw = rw_i;
        repeat (QC - 5) @(negedge clk);
      end else begin
        repeat (QC) @(negedge clk);
      end
      bus_q = 1'b0;
      repeat (QC) @(negedge clk);
      bus_e  = 1'b0;
      bus_rw = 1'b1;
      bus_cs = 1'b0;
      repeat (QC) @(negedge clk);
      if (!rw_i && cs_i && !late) want_strobes++;
    endtask

    initial begin
      @(posedge rst_n);
      repeat (3) @(negedge clk);
      checks++;  // R9 static budget flag
      if (cfg_err !== ERR_E) begin
        failures++;
        $display("FAIL R9 blk%0d cfg_err actual=%b expected=%b", g, cfg_err, ERR_E);
      end
      repeat (10) @(negedge clk);
      bus_cycle(1'b0, 1'b1, 3'd1, 1'b0);
      bus_cycle(1'b1, 1'b1, 3'd2, 1'b0);
      bus_cycle(1'b0, 1'b0, 3'd3, 1'b0);
      bus_cycle(1'b0, 1'b1, 3'd5, 1'b0);
      bus_cycle(1'b0, 1'b1, 3'd7, 1'b1);
      bus_cycle(1'b0, 1'b1, 3'd7, 1'b0);
      bus_cycle(1'b1, 1'b0, 3'd0, 1'b0);
      bus_cycle(1'b0, 1'b1, 3'd0, 1'b0);
      bus_cycle(1'b0, 1'b1, 3'd6, 1'b0);
      repeat (20) @(negedge clk);
      checks++;  // R7 and R6: one strobe per selected write only
      if (strobes != want_strobes) begin
        failures++;
        $display("FAIL R7 blk%0d strobe count actual=%0d expected=%0d", g, strobes, want_strobes);
      end
      done_cnt++;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    checks++;  // R1 outputs idle during reset
    if (g_blk[0].per_cs_n !== 1'b1 || g_blk[0].per_wr_n !== 1'b1) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%b%b expected=11",
               g_blk[0].per_cs_n, g_blk[0].per_wr_n);
    end
    checks++;  // R1 on the error-configured instance
    if (g_blk[3].per_cs_n !== 1'b1 || g_blk[3].per_wr_n !== 1'b1) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%b%b expected=11",
               g_blk[3].per_cs_n, g_blk[3].per_wr_n);
    end
    rst_n = 1'b1;
    fork
      wait (done_cnt == 4);
      begin
        repeat (WD_CYC) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule